// File: doc/BRIEF.md
# Externally Clocked Event Timer with Phase-Qualified Synchronizer

This block counts rising edges that arrive on an asynchronous input pin and holds the result in a loadable up-counter. The pin can be routed straight into the synchronizer. It can also pass first through a power-of-two divider that the pin itself clocks. A free-running two-bit phase register splits the oscillator clock into four-phase cycles. The synchronized signal is sampled on the edges that end the second and fourth phases. A detected low-to-high sample transition advances the counter on the next edge that ends a fourth phase.

The counter is the only state that software-style logic touches. A load writes a new value, clears the sticky wrap flag, resets the divider, and masks counting for a short window. The wrap flag records any roll-over from the all-ones value to zero.

Phase numbering: after reset the phase register is 0. It advances by one on every clock edge. An edge taken while it holds 1 ends phase Q2, and an edge taken while it holds 3 ends phase Q4.

Top module: `ext_event_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `count` is 0 and `wrapped` is 0. The divider and the phase register are also cleared.
- R2: With `div_en` = 0, each pin rising edge increments `count` by exactly one, provided the pin stays high for at least 3 clock periods and low for at least 3 clock periods.
- R3: With `div_en` = 0 and the pin changing between clock edges, `count` is unchanged after the third rising clock edge following the pin rise. It has incremented by the seventh.
- R4: `count` advances only on edges that end phase Q4, so at most once per four clock edges. With `div_en` = 0, a pin with 2 periods high and 2 periods low is still counted on every rising edge.
- R5: With `div_en` = 0, a pin pulse exactly one clock period wide is caught or missed depending on its phase alignment. Of four such pulses at four consecutive alignments, exactly two are counted.
- R6: With `div_en` = 1, the synchronized signal is divider bit `div_sel`, giving a ratio of 2^(`div_sel`+1). Starting from a cleared divider, n pin rises give floor((n + 2^`div_sel`) / 2^(`div_sel`+1)) increments.
- R7: With `div_en` = 1 and `div_sel` = 0, a pin with a period of 2 clock periods (1 high, 1 low) is counted exactly at the divided rate.
- R8: An increment from all-ones gives 0 and sets `wrapped`.
- R9: `wrapped` stays set through later increments until a load or reset clears it.
- R10: A load with `load_en` = 1 puts `load_val` on `count` after that clock edge and clears `wrapped`. A load takes priority over an increment in the same cycle.
- R11: A load resets the divider count, so pin edges seen before the load do not add to the division afterwards.
- R12: After a load, increments due on the next two Q4-ending edges are dropped. A pin rise already in flight when the load happens is therefore not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_pin | input | 1 | Asynchronous external event input |
| div_en | input | 1 | 1 routes the pin through the divider |
| div_sel | input | SEL_W (3) | Divider bit select; ratio 2^(div_sel+1) |
| load_en | input | 1 | Load strobe for the counter |
| load_val | input | CNT_W (8) | Value written on a load |
| count | output | CNT_W (8) | Current counter value |
| wrapped | output | 1 | Sticky roll-over flag |

## Verification
The bench steps a pin rise through all four phase alignments and brackets its latency. A design that counted on every sample edge would move too early, and one that lost the pending edge would never move. Single-period pulses at consecutive alignments must give exactly two counts: a synchronizer that samples every clock counts all four, and one without phase gating counts an arbitrary number. Scripted sequences confirm that a load flushes the divider and drops an in-flight edge. A design that skipped either step would end one count high. The wrap test checks that the flag survives later increments and that only a load clears it.

// File: rtl/ext_event_timer.sv
module ext_event_timer #(
  parameter int CNT_W    = 8,
  parameter int DIV_W    = 8,
  parameter int SEL_W    = $clog2(DIV_W),
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_pin,
  input  logic             div_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrapped
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [1:0]       ph;
  logic             meta, smp, pend, clr_q;
  logic [HOLD_W-1:0] hold;
  logic [DIV_W-1:0] div_cnt;

  wire div_rst  = !rst_n || clr_q;
  wire sel_sig  = div_en ? div_cnt[div_sel] : tick_pin;
  wire q2_end   = (ph == 2'd1);
  wire q4_end   = (ph == 2'd3);
  wire smp_edge = q2_end || q4_end;
  wire rise     = smp_edge && meta && !smp;
  wire step     = q4_end && pend && (hold == '0) && !load_en;

  always_ff @(posedge tick_pin or posedge div_rst)
    if (div_rst) div_cnt <= '0;
    else         div_cnt <= div_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph      <= '0;
      meta    <= 1'b0;
      smp     <= 1'b0;
      pend    <= 1'b0;
      clr_q   <= 1'b0;
      hold    <= '0;
      count   <= '0;
      wrapped <= 1'b0;
    end else begin
      ph    <= ph + 2'd1;
      meta  <= sel_sig;
      clr_q <= load_en;
      if (smp_edge) smp <= meta;
      if (q2_end) pend <= pend || rise;
      if (q4_end) pend <= rise;
      if (load_en) begin
        count   <= load_val;
        wrapped <= 1'b0;
        hold    <= HOLD_W'(HOLD_CYC);
      end else begin
        if (q4_end && hold != '0) hold <= hold - 1'b1;
        if (step) begin
          count <= count + 1'b1;
          if (count == '1) wrapped <= 1'b1;
        end
      end
    end

  a_r4_q4_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!q4_end && !load_en) |=> $stable(count));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (q4_end && !load_en) |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val) && !wrapped));

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && count == '1 && !wrapped) |=> (count == '1 || (count == '0 && wrapped)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !load_en) |=> wrapped);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0 && !load_en) |=> $stable(count));

endmodule

// File: tb/ext_event_timer_tb_top.sv
module ext_event_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_pin = 1'b0;
  logic       div_en = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       load_en = 1'b0;
  logic [7:0] load_val = 8'h00;
  logic [7:0] count;
  logic       wrapped;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ext_event_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_pin(tick_pin), .div_en(div_en),
    .div_sel(div_sel), .load_en(load_en), .load_val(load_val),
    .count(count), .wrapped(wrapped)
  );

  // {div_en, div_sel, rises[11:0], expected[7:0]}
  localparam int VN = 9;
  localparam logic [23:0] VEC [VN] = '{
    {1'b0, 3'd0, 12'd5,   8'd5},
    {1'b0, 3'd0, 12'd9,   8'd9},
    {1'b1, 3'd0, 12'd8,   8'd4},
    {1'b1, 3'd1, 12'd8,   8'd2},
    {1'b1, 3'd2, 12'd16,  8'd2},
    {1'b1, 3'd3, 12'd16,  8'd1},
    {1'b1, 3'd4, 12'd40,  8'd1},
    {1'b1, 3'd5, 12'd100, 8'd2},
    {1'b1, 3'd7, 12'd300, 8'd1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    load_en = 1'b1; load_val = v;
    cyc(1);
    load_en = 1'b0;
  endtask

  task automatic rises(input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      tick_pin = 1'b1; cyc(hi);
      tick_pin = 1'b0; cyc(lo);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 count in reset", count, 8'h00);
    chk("R1 flag in reset", {7'd0, wrapped}, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 count after reset", count, 8'h00);

    // R2 / R6: table walk
    for (int i = 0; i < VN; i++) begin
      load(8'h00);
      div_en = VEC[i][23]; div_sel = VEC[i][22:20];
      cyc(12);
      rises(int'(VEC[i][19:8]), 3, 3);
      cyc(12);
      chk(VEC[i][23] ? "R6 divided count" : "R2 direct count", count, VEC[i][7:0]);
    end

    // R3: latency at four alignments (13 cycles per round shifts phase)
    div_en = 1'b0;
    load(8'h00); cyc(12);
    for (int a = 0; a < 4; a++) begin
      tick_pin = 1'b1;
      cyc(3);
      chk("R3 no early step", count, 8'(a));
      cyc(4);
      chk("R3 step by seventh edge", count, 8'(a + 1));
      tick_pin = 1'b0;
      cyc(6);
    end

    // R4: minimum 2/2 pulse widths
    load(8'h00); cyc(12);
    rises(10, 2, 2);
    cyc(12);
    chk("R4 two-period pulses", count, 8'd10);

    // R5: single-period pulses at four alignments
    load(8'h00); cyc(12);
    for (int a = 0; a < 4; a++) begin
      tick_pin = 1'b1; cyc(1);
      tick_pin = 1'b0; cyc(16);
    end
    chk("R5 half of narrow pulses", count, 8'd2);

    // R7: fast pin through divider
    div_en = 1'b1; div_sel = 3'd0;
    load(8'h00); cyc(12);
    rises(16, 1, 1);
    cyc(12);
    chk("R7 fast pin divided", count, 8'd8);

    // R8 / R9 / R10: wrap and sticky flag
    div_en = 1'b0;
    load(8'hFE); cyc(12);
    rises(1, 3, 3); cyc(8);
    chk("R8 before wrap", count, 8'hFF);
    chk("R8 flag before wrap", {7'd0, wrapped}, 8'h00);
    rises(1, 3, 3); cyc(8);
    chk("R8 wrap to zero", count, 8'h00);
    chk("R8 flag set", {7'd0, wrapped}, 8'h01);
    rises(1, 3, 3); cyc(8);
    chk("R9 flag sticky", {7'd0, wrapped}, 8'h01);
    chk("R9 count after wrap", count, 8'h01);
    load(8'h10);
    chk("R10 load value", count, 8'h10);
    chk("R10 load clears flag", {7'd0, wrapped}, 8'h00);

    // R11: load flushes divider
    div_en = 1'b1; div_sel = 3'd2;
    load(8'h00); cyc(12);
    rises(2, 3, 3); cyc(12);
    chk("R11 partial divide", count, 8'h00);
    load(8'h40); cyc(12);
    rises(3, 3, 3); cyc(12);
    chk("R11 divider cleared by load", count, 8'h40);

    // R12: in-flight edge dropped after load
    div_en = 1'b0;
    load(8'h20); cyc(12);
    tick_pin = 1'b1; cyc(1);
    load(8'h30);
    cyc(12);
    chk("R12 in-flight edge dropped", count, 8'h30);
    tick_pin = 1'b0; cyc(12);
    rises(1, 3, 3); cyc(12);
    chk("R12 counting resumes", count, 8'h31);

    // R1: reset mid-run
    load(8'h55); cyc(4);
    rst_n = 1'b0; cyc(2);
    chk("R1 mid-run reset count", count, 8'h00);
    chk("R1 mid-run reset flag", {7'd0, wrapped}, 8'h00);
    rst_n = 1'b1; cyc(2);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule